// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog down-counter that software can only service by writing a control word carrying the right key. The control word holds three things: an initial count, a run command and a 7-bit key. While the watchdog is running, a write is taken only if its key is the bitwise inverse of the key already stored. Any other write is dropped without effect. This stops a runaway program from keeping the watchdog alive by writing one constant value over and over.

Expiry escalates in two steps. The first expiry raises a level-sensitive non-maskable interrupt and reloads the counter with a short grace count. If the grace count also runs out before a valid service write arrives, the block emits a one-cycle system reset request and the counter stops. A valid service write clears the interrupt and the escalation history.

The counter advances only on cycles where the `tick_en` input is high, so an external prescaler sets the timebase. A status word gives read access to the live count and the interrupt flag.

Top module: `wdk_top`

## Requirements
- R1: After synchronous reset the stored control word is 0, the counter is stopped at 0, and `nmi_o` and `sysrst_req_o` are low.
- R2: While the stored run bit (bit 8) is 0, a write to offset 0x40 is accepted whatever its key. The whole written word becomes the stored control word, and a read of 0x40 returns it.
- R3: While the stored run bit is 1, a write to 0x40 whose key field (bits [15:9]) differs from the bitwise inverse of the stored key is ignored. The control word, count, run state and `nmi_o` are all unchanged.
- R4: An accepted write loads the counter from bits [7:0]. A field value of 0 loads 256.
- R5: The counter decrements by one on each cycle with `tick_en` high, but only while running. It runs when the accepted bit 8 is 1 and holds its value when bit 8 is 0.
- R6: When a running count of N has seen N ticks and no expiry has happened since the last accepted write, `nmi_o` goes high and stays high. At the same time the counter reloads with GRACE_TICKS and keeps running.
- R7: An expiry that follows an unserviced first expiry drives `sysrst_req_o` high for exactly one cycle. The counter then stops at 0.
- R8: An accepted write drops `nmi_o` and clears the escalation history, so the next expiry counts as a first expiry again.
- R9: A read of offset 0x44 returns the count in bits [8:0] and the `nmi_o` state in bit 16. Read data appears one cycle after `rd_en`. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable pulse from the prescaler |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| nmi_o | output | 1 | Non-maskable interrupt level |
| sysrst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with GRACE_TICKS set to 2 instead of the default of 1. This makes the grace window observable: there is one tick where the interrupt is up but the reset request has not yet fired, and the status read shows a reloaded count that is distinct from a simple decrement. Short initial counts of 3 and 4 let the test drive the full chain in a few ticks. That chain is enable, rejected key, first expiry, second expiry, service, and re-arm. The zero-means-256 load is checked through the status word rather than by counting down all 256 ticks.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic {
    STG_ARMED  = 1'b0,
    STG_WARNED = 1'b1
  } wdk_stage_e;
endpackage

// File: rtl/wdk_keygate.sv
module wdk_keygate #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 8,
  parameter int KEY_W    = 7,
  parameter int CTRL_OFS = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              accept,
  output logic [CNT_W:0]    load_val,
  output logic              load_run
);
  localparam int CMD_BIT = CNT_W;
  localparam int KEY_LO  = CNT_W + 1;
  localparam int KEY_HI  = KEY_LO + KEY_W - 1;
  localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

  logic             hit;
  logic [KEY_W-1:0] want_key;

  always_comb begin
    hit      = wr_en && (addr == ADDR_W'(CTRL_OFS));
    want_key = ~ctrl_q[KEY_HI:KEY_LO];
    accept   = hit && (!ctrl_q[CMD_BIT] || (wdata[KEY_HI:KEY_LO] == want_key));
    load_run = wdata[CMD_BIT];
    load_val = (wdata[CNT_W-1:0] == '0) ? FULL_CNT : {1'b0, wdata[CNT_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (accept) ctrl_q <= wdata;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W       = 8,
  parameter int GRACE_TICKS = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_en,
  input  logic           load,
  input  logic [CNT_W:0] load_val,
  input  logic           load_run,
  input  logic           reload_grace,
  input  logic           halt,
  output logic [CNT_W:0] cnt_q,
  output logic           run_q,
  output logic           expire
);
  localparam logic [CNT_W:0] GRACE_VAL = (CNT_W+1)'(GRACE_TICKS);

  assign expire = run_q && tick_en && (cnt_q == (CNT_W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= load_run;
    end else if (reload_grace) begin
      cnt_q <= GRACE_VAL;
    end else if (halt) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdk_escalate.sv
module wdk_escalate
  import wdk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic service,
  input  logic expire,
  output logic reload_grace,
  output logic halt,
  output logic nmi_q,
  output logic rstreq_q
);
  wdk_stage_e stage_q;

  always_comb begin
    reload_grace = expire && !service && (stage_q == STG_ARMED);
    halt         = expire && !service && (stage_q == STG_WARNED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= STG_ARMED;
      nmi_q    <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      rstreq_q <= halt;
      if (service) begin
        stage_q <= STG_ARMED;
        nmi_q   <= 1'b0;
      end else if (reload_grace) begin
        stage_q <= STG_WARNED;
        nmi_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 8,
  parameter int KEY_W       = 7,
  parameter int GRACE_TICKS = 1,
  parameter int CTRL_OFS    = 'h40,
  parameter int STAT_OFS    = 'h44,
  parameter int NMI_BIT     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              nmi_o,
  output logic              sysrst_req_o
);
  localparam int VAL_W = CNT_W + 1;

  logic [DATA_W-1:0] ctrl_q;
  logic              accept;
  logic [CNT_W:0]    load_val;
  logic              load_run;
  logic [CNT_W:0]    cnt_q;
  logic              run_q;
  logic              expire;
  logic              reload_grace;
  logic              halt;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] rd_mux;

  wdk_keygate #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .KEY_W(KEY_W), .CTRL_OFS(CTRL_OFS)
  ) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .accept(accept), .load_val(load_val), .load_run(load_run)
  );

  wdk_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load(accept),
    .load_val(load_val), .load_run(load_run), .reload_grace(reload_grace),
    .halt(halt), .cnt_q(cnt_q), .run_q(run_q), .expire(expire)
  );

  wdk_escalate u_esc (
    .clk(clk), .rst(rst), .service(accept), .expire(expire),
    .reload_grace(reload_grace), .halt(halt),
    .nmi_q(nmi_o), .rstreq_q(sysrst_req_o)
  );

  always_comb begin
    stat_w            = '0;
    stat_w[VAL_W-1:0] = cnt_q;
    stat_w[NMI_BIT]   = nmi_o;
    if (addr == ADDR_W'(CTRL_OFS))      rd_mux = ctrl_q;
    else if (addr == ADDR_W'(STAT_OFS)) rd_mux = stat_w;
    else                                rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 8,
  parameter int KEY_W    = 7,
  parameter int CTRL_OFS = 'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              accept,
  input logic [CNT_W:0]    cnt_q,
  input logic              run_q,
  input logic              nmi_o,
  input logic              sysrst_req_o
);
  localparam int KEY_LO = CNT_W + 1;
  localparam int KEY_HI = KEY_LO + KEY_W - 1;

  logic bad_key;
  assign bad_key = wr_en && (addr == ADDR_W'(CTRL_OFS)) && ctrl_q[CNT_W] &&
                   (wdata[KEY_HI:KEY_LO] != ~ctrl_q[KEY_HI:KEY_LO]);

  // R1
  post_reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_q == '0 && !nmi_o && !sysrst_req_o && !run_q));

  // R3
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    bad_key |=> ($stable(ctrl_q) && !$rose(nmi_o) || $rose(nmi_o)) && $stable(ctrl_q));

  // R5
  stopped_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !accept) |=> $stable(cnt_q));

  // R6
  nmi_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_o) |-> $past(run_q));

  // R7
  rstreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sysrst_req_o |=> !sysrst_req_o);

  // R7
  rstreq_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    sysrst_req_o |-> (nmi_o && !run_q));

  // R8
  service_drops_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !nmi_o);
endmodule

bind wdk_top wdk_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
  .KEY_W(KEY_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl_q(ctrl_q), .accept(accept), .cnt_q(cnt_q), .run_q(run_q),
  .nmi_o(nmi_o), .sysrst_req_o(sysrst_req_o)
);

// File: tb/sim_wdk_top.sv
module sim_wdk_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int GRACE  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              nmi_o;
  logic              sysrst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } sb_item_t;
  sb_item_t sbq[$];
  logic     rd_pend = 1'b0;

  always #2 clk = ~clk;

  wdk_top #(.GRACE_TICKS(GRACE)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .nmi_o(nmi_o),
    .sysrst_req_o(sysrst_req_o)
  );

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s rdata act=%h exp=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic pin(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pin act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input logic [DATA_W-1:0] e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    addr  = ADDR_W'(a);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [DATA_W-1:0] d);
    addr  = 8'h40;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    pin(nmi_o, 1'b0, "R1 nmi");
    pin(sysrst_req_o, 1'b0, "R1 rstreq");
    rd('h40, 32'h0, "R1 ctrl");
    rd('h44, 32'h0, "R1 stat");
    // R2 enable with key 0x15, count 4
    wr(32'h2B04);
    rd('h40, 32'h2B04, "R2 ctrl stored");
    rd('h44, 32'h4, "R4 load");
    // R5
    tick(2);
    rd('h44, 32'h2, "R5 decrement");
    // R3 same key again: rejected
    wr(32'h2B09);
    rd('h40, 32'h2B04, "R3 ctrl kept");
    rd('h44, 32'h2, "R3 count kept");
    // R6
    tick(1);
    pin(nmi_o, 1'b0, "R6 nmi early");
    tick(1);
    pin(nmi_o, 1'b1, "R6 nmi raised");
    rd('h44, 32'h10002, "R6 grace reload");
    // R7
    tick(1);
    pin(sysrst_req_o, 1'b0, "R7 rstreq early");
    tick(1);
    pin(sysrst_req_o, 1'b1, "R7 rstreq fired");
    @(negedge clk);
    pin(sysrst_req_o, 1'b0, "R7 rstreq pulse");
    tick(3);
    rd('h44, 32'h10000, "R7 stopped");
    // R8 service with key 0x6A, count 3
    wr(32'hD503);
    pin(nmi_o, 1'b0, "R8 nmi cleared");
    rd('h44, 32'h3, "R8 reload");
    tick(3);
    pin(nmi_o, 1'b1, "R8 first stage again");
    pin(sysrst_req_o, 1'b0, "R8 no reset");
    rd('h44, 32'h10002, "R8 grace again");
    // R4 zero count, cmd 0, key 0x15
    wr(32'h2A00);
    pin(nmi_o, 1'b0, "R8 nmi cleared 2");
    rd('h44, 32'h100, "R4 zero means 256");
    tick(5);
    rd('h44, 32'h100, "R5 hold when stopped");
    // R2 disabled: arbitrary key
    wr(32'hFF02);
    rd('h40, 32'hFF02, "R2 any key");
    // R9
    rd('h48, 32'h0, "R9 unmapped");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule